// File: doc/BRIEF.md
# Queued Serial Master with Per-Word Chip Select

This block is a synchronous serial master driven from a queue of transfer entries. Each entry pairs a two-bit chip-select code with an 8-bit data word. Software first issues a pointer clear and sets a batch length. It then loads entries by writing a select code followed by a data word. Writing the data word pushes the entry, and that push is what starts the serial engine.

The engine shifts each word out on `so`, most significant bit first, with `sck` idling low. The output changes on the rising edge and the input is sampled on the falling edge. For each word it pulls the chip-select line named by that entry low. The bits arriving on `si` are collected into a receive queue. If the transmit queue runs dry before the batch is finished, the clock parks low and the select lines hold until another entry arrives.

When the programmed number of words has completed, a one-cycle completion pulse is raised. Software then drains the received words in arrival order through a single read port. In receive-only mode the transmitted words are only dummies that generate clocks, and the data output keeps its last level.

Top module: `qspi_cs_queue`

## Requirements
- R1: Each word is 8 bits and is sent MSB first. `sck` idles low. `so` changes only together with a rising `sck` edge, and `si` is sampled at the falling edge. One `sck` half period lasts HALF clock cycles.
- R2: A pulse on `sel_we` stores `sel_val`. A pulse on `dat_we` pushes that stored code together with `dat_val` as one entry. While the entry's word is shifted, select code k drives `cs_n[k]` low and the other lines high. At most one line is low at any time, and the code may differ from word to word.
- R3: `cnt_val` written with `cnt_we` sets the batch length; the value 0 means 16. After exactly that many words the engine stops, `cs_n` returns to 4'hF, and further queued entries are not sent.
- R4: `done_irq` is high for exactly one cycle, in the cycle right after the last word of the batch ends. With the engine idle, a single-word batch raises it 17*HALF+1 cycles after the clock edge that accepts the data write.
- R5: `ptr_clr` empties both queues, restarts the batch count, stops any word in progress, and sets `cs_n` to 4'hF and `sck` to 0. Entries still queued are discarded.
- R6: `full` is high when 16 entries are waiting. A data write while `full` is high is dropped.
- R7: If the batch is not finished and no entry is queued, `sck` stays low and `cs_n` keeps the last word's value. Shifting resumes when an entry is written.
- R8: While `rx_only` is 1, `so` holds its level and the queued words serve only as clock generators.
- R9: With `rx_en` at 1, each completed word is stored. The stored words are read in arrival order on `rx_data`, and a pulse on `rx_re` advances to the next word. `rx_avail` shows that data is waiting. With `rx_en` at 0, nothing is stored.
- R10: While `en` is 0, the serial engine is frozen: `sck`, `cs_n` and the word progress do not change.
- R11: After reset, `sck`=0, `so`=0, `cs_n`=4'hF, and `done_irq`, `full` and `rx_avail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable |
| rx_en | input | 1 | Store received words |
| rx_only | input | 1 | Receive-only mode, `so` held |
| cnt_we | input | 1 | Write strobe for the batch length |
| cnt_val | input | 4 | Batch length (0 means 16) |
| ptr_clr | input | 1 | Clear both queues and the batch progress |
| sel_we | input | 1 | Write strobe for the select code |
| sel_val | input | 2 | Chip-select code for the next entry |
| dat_we | input | 1 | Data write, pushes an entry |
| dat_val | input | 8 | Data word of the entry |
| full | output | 1 | Transmit queue full |
| rx_re | input | 1 | Advance the receive read pointer |
| rx_data | output | 8 | Oldest received word |
| rx_avail | output | 1 | Receive queue not empty |
| done_irq | output | 1 | Batch completion pulse |
| sck | output | 1 | Serial clock |
| so | output | 1 | Serial data out |
| cs_n | output | 4 | Chip selects, active low |
| si | input | 1 | Serial data in |

## Verification
With HALF=2 and an idle engine, the word from a data write accepted at edge W starts at edge W+1. Its bits rise every 4 cycles from W+3, its last fall is at W+33, and `done_irq` is high only in the cycle after edge W+35. The bench samples on the falling clock edge on both sides of that point. A bus model in the bench collects `so` and `cs_n` at each falling `sck` and drives `si` at each rising edge, so word contents are checked in serial time rather than in clock cycles. `full`, `rx_avail` and `rx_data` are registered or combinational on queue pointers, so they are checked at the falling clock edge that follows the write or read strobe.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int WORD_W   = 8;
  localparam int CS_LINES = 4;
  localparam int CS_W     = $clog2(CS_LINES);
  localparam int CNT_W    = 4;
  localparam int DEPTH    = 1 << CNT_W;
  localparam int TGT_W    = CNT_W + 1;
  localparam int ENTRY_W  = CS_W + WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [CS_W-1:0] sel;
    word_t           data;
  } entry_t;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_WAIT,
    ENG_GAP,
    ENG_HIGH,
    ENG_LOW
  } eng_state_t;

  // batch length: a zero field selects the full queue depth
  function automatic logic [TGT_W-1:0] batch_target(input logic [CNT_W-1:0] cnt);
    return (cnt == '0) ? TGT_W'(DEPTH) : {1'b0, cnt};
  endfunction

  // select code to active-low line vector
  function automatic logic [CS_LINES-1:0] sel_to_csn(input logic [CS_W-1:0] sel);
    return ~(CS_LINES'(1) << sel);
  endfunction
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr;
  logic [AW:0]  rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (pop)  rd_ptr <= rd_ptr + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rd_ptr[AW-1:0]];
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic                rx_only,
  input  logic [TGT_W-1:0]    tgt,
  input  logic                ent_valid,
  input  entry_t              ent,
  input  logic                si,
  output logic                ent_pop,
  output logic                word_end,
  output logic                busy,
  output logic                done_irq,
  output logic                sck,
  output logic                so,
  output logic [CS_LINES-1:0] cs_n,
  output word_t               rx_word
);
  localparam int TW  = $clog2(HALF + 1);
  localparam int BW  = $clog2(WORD_W);
  localparam int MSB = WORD_W - 1;

  eng_state_t       state;
  logic [TW-1:0]    tmr;
  logic [BW-1:0]    bit_idx;
  logic [TGT_W-1:0] done_cnt;
  word_t            sh;
  logic             half_up;
  logic             last_bit;
  logic             more_left;

  assign half_up   = (tmr == TW'(HALF - 1));
  assign last_bit  = (bit_idx == BW'(MSB));
  assign more_left = (done_cnt + TGT_W'(1)) < tgt;
  assign busy      = (state == ENG_GAP) || (state == ENG_HIGH) || (state == ENG_LOW);

  always_comb begin
    word_end = en && !clr && (state == ENG_LOW) && half_up && last_bit;
    ent_pop  = 1'b0;
    if (en && !clr) begin
      if (state == ENG_IDLE)      ent_pop = ent_valid && (done_cnt < tgt);
      else if (state == ENG_WAIT) ent_pop = ent_valid;
      else if (word_end)          ent_pop = ent_valid && more_left;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      tmr      <= '0;
      bit_idx  <= '0;
      done_cnt <= '0;
      done_irq <= 1'b0;
      sck      <= 1'b0;
      so       <= 1'b0;
      cs_n     <= '1;
      sh       <= '0;
      rx_word  <= '0;
    end else if (clr) begin
      state    <= ENG_IDLE;
      tmr      <= '0;
      bit_idx  <= '0;
      done_cnt <= '0;
      done_irq <= 1'b0;
      sck      <= 1'b0;
      cs_n     <= '1;
    end else begin
      done_irq <= word_end && !more_left;
      if (en) begin
        case (state)
          ENG_IDLE, ENG_WAIT: begin
            if (ent_pop) begin
              sh      <= ent.data;
              cs_n    <= sel_to_csn(ent.sel);
              bit_idx <= '0;
              tmr     <= '0;
              state   <= ENG_GAP;
            end
          end
          ENG_GAP: begin
            if (half_up) begin
              sck   <= 1'b1;
              if (!rx_only) so <= sh[MSB];
              tmr   <= '0;
              state <= ENG_HIGH;
            end else begin
              tmr <= tmr + TW'(1);
            end
          end
          ENG_HIGH: begin
            if (half_up) begin
              sck     <= 1'b0;
              rx_word <= {rx_word[MSB-1:0], si};
              sh      <= sh << 1;
              tmr     <= '0;
              state   <= ENG_LOW;
            end else begin
              tmr <= tmr + TW'(1);
            end
          end
          ENG_LOW: begin
            if (half_up) begin
              tmr <= '0;
              if (last_bit) begin
                done_cnt <= done_cnt + TGT_W'(1);
                if (!more_left) begin
                  cs_n  <= '1;
                  state <= ENG_IDLE;
                end else if (ent_pop) begin
                  sh      <= ent.data;
                  cs_n    <= sel_to_csn(ent.sel);
                  bit_idx <= '0;
                  state   <= ENG_GAP;
                end else begin
                  state <= ENG_WAIT;
                end
              end else begin
                bit_idx <= bit_idx + BW'(1);
                sck     <= 1'b1;
                if (!rx_only) so <= sh[MSB];
                state   <= ENG_HIGH;
              end
            end else begin
              tmr <= tmr + TW'(1);
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_cs_queue.sv
module qspi_cs_queue
  import qspi_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rx_en,
  input  logic                rx_only,
  input  logic                cnt_we,
  input  logic [CNT_W-1:0]    cnt_val,
  input  logic                ptr_clr,
  input  logic                sel_we,
  input  logic [CS_W-1:0]     sel_val,
  input  logic                dat_we,
  input  logic [WORD_W-1:0]   dat_val,
  output logic                full,
  input  logic                rx_re,
  output logic [WORD_W-1:0]   rx_data,
  output logic                rx_avail,
  output logic                done_irq,
  output logic                sck,
  output logic                so,
  output logic [CS_LINES-1:0] cs_n,
  input  logic                si
);
  logic [CNT_W-1:0]   cnt_reg;
  logic [CS_W-1:0]    sel_stage;
  logic [ENTRY_W-1:0] tx_rdata;
  entry_t             tx_head;
  entry_t             tx_new;
  logic               tx_empty;
  logic               tx_full;
  logic               tx_push;
  logic               rx_empty;
  logic               rx_full;
  logic               rx_push;
  logic               rx_pop;
  word_t              rx_word;
  // named internal events used by the checker
  logic               eng_pop;
  logic               eng_word_end;
  logic               eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_reg   <= '0;
      sel_stage <= '0;
    end else begin
      if (cnt_we) cnt_reg   <= cnt_val;
      if (sel_we) sel_stage <= sel_val;
    end
  end

  assign tx_new  = '{sel: sel_stage, data: dat_val};
  assign tx_push = dat_we && !tx_full;
  assign tx_head = tx_rdata;

  qspi_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
    .push(tx_push), .wdata(tx_new),
    .pop(eng_pop), .rdata(tx_rdata),
    .empty(tx_empty), .full(tx_full)
  );

  qspi_engine #(.HALF(HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(ptr_clr), .rx_only(rx_only),
    .tgt(batch_target(cnt_reg)), .ent_valid(!tx_empty), .ent(tx_head), .si(si),
    .ent_pop(eng_pop), .word_end(eng_word_end), .busy(eng_busy),
    .done_irq(done_irq), .sck(sck), .so(so), .cs_n(cs_n), .rx_word(rx_word)
  );

  assign rx_push = eng_word_end && rx_en && !rx_full;
  assign rx_pop  = rx_re && !rx_empty;

  qspi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
    .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_data),
    .empty(rx_empty), .full(rx_full)
  );

  assign full     = tx_full;
  assign rx_avail = !rx_empty;
endmodule

// File: rtl/qspi_cs_queue_chk.sv
module qspi_cs_queue_chk
  import qspi_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                ptr_clr,
  input logic                rx_only,
  input logic                sck,
  input logic                so,
  input logic [CS_LINES-1:0] cs_n,
  input logic                done_irq,
  input logic                full,
  input logic                busy,
  input logic                word_end
);
  assert_so_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $rose(sck));

  assert_sck_in_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sck_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (cs_n != '1));

  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_irq_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(word_end));

  assert_clr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (!full && !sck && cs_n == '1));

  assert_so_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_only && $past(rx_only)) |-> $stable(so));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ptr_clr) |=> ($stable(sck) && $stable(cs_n)));
endmodule

bind qspi_cs_queue qspi_cs_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ptr_clr(ptr_clr), .rx_only(rx_only),
  .sck(sck), .so(so), .cs_n(cs_n), .done_irq(done_irq), .full(full),
  .busy(eng_busy), .word_end(eng_word_end)
);

// File: tb/qspi_cs_queue_tb.sv
module qspi_cs_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, rx_en = 1'b1, rx_only = 1'b0;
  logic       cnt_we = 1'b0, ptr_clr = 1'b0, sel_we = 1'b0, dat_we = 1'b0, rx_re = 1'b0;
  logic [3:0] cnt_val = '0;
  logic [1:0] sel_val = '0;
  logic [7:0] dat_val = '0;
  logic       si = 1'b0;
  logic       full, rx_avail, done_irq, sck, so;
  logic [7:0] rx_data;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qspi_cs_queue u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_en(rx_en), .rx_only(rx_only),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .ptr_clr(ptr_clr),
    .sel_we(sel_we), .sel_val(sel_val), .dat_we(dat_we), .dat_val(dat_val),
    .full(full), .rx_re(rx_re), .rx_data(rx_data), .rx_avail(rx_avail),
    .done_irq(done_irq), .sck(sck), .so(so), .cs_n(cs_n), .si(si)
  );

  // bus model: drives si on rising sck, records so and cs_n on falling sck
  logic [7:0] sl_rep [64];
  logic [7:0] m_word [64];
  logic [3:0] m_cs   [64];
  logic [7:0] sl_cur = '0;
  logic [7:0] m_sh = '0;
  int         m_n = 0;
  int         sl_bit = 0;

  always @(posedge sck) begin
    if (rst_n) begin
      if (sl_bit == 0) sl_cur = sl_rep[m_n];
      si = sl_cur[7 - sl_bit];
    end
  end

  always @(negedge sck) begin
    if (rst_n) begin
      m_sh = {m_sh[6:0], so};
      if (sl_bit == 7) begin
        m_word[m_n] = m_sh;
        m_cs[m_n]   = cs_n;
        m_n         = m_n + 1;
        sl_bit      = 0;
      end else begin
        sl_bit = sl_bit + 1;
      end
    end
  end

  // {select code, transmitted word, word returned by the bus model}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'h3C}, {2'd3, 8'h5A, 8'hC3}, {2'd1, 8'hFF, 8'h00},
    {2'd2, 8'h00, 8'hFF}, {2'd1, 8'h81, 8'h7E}, {2'd0, 8'h6B, 8'h94}
  };

  function automatic logic [3:0] exp_csn(input logic [1:0] s);
    logic [3:0] v = 4'hF;
    v[s] = 1'b0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    ptr_clr = 1'b1; @(posedge clk); @(negedge clk); ptr_clr = 1'b0;
  endtask

  task automatic set_count(input logic [3:0] n);
    cnt_val = n; cnt_we = 1'b1; @(posedge clk); @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic put_entry(input logic [1:0] s, input logic [7:0] d);
    sel_val = s; sel_we = 1'b1; @(posedge clk); @(negedge clk); sel_we = 1'b0;
    dat_val = d; dat_we = 1'b1; @(posedge clk); @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string tag);
    bit got = 1'b0;
    for (int n = 0; n < limit && !got; n++) begin
      @(negedge clk);
      if (done_irq) got = 1'b1;
    end
    chk(got, tag, 32'(got), 32'd1);
  endtask

  task automatic read_rx(input logic [7:0] exp, input string tag);
    chk(rx_avail && rx_data == exp, tag, {23'd0, rx_avail, rx_data}, {24'd1, exp});
    rx_re = 1'b1; @(posedge clk); @(negedge clk); rx_re = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic lvl;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cs_n == 4'hF && !sck && !so && !done_irq && !full && !rx_avail, "R11 reset outputs",
        {cs_n, sck, so, done_irq, full, rx_avail}, {4'hF, 5'd0});
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R9 word content, select per entry, receive order
    pulse_clr();
    set_count(4'd6);
    base = m_n;
    for (int i = 0; i < 6; i++) sl_rep[base + i] = VEC[i][7:0];
    for (int i = 0; i < 6; i++) put_entry(VEC[i][17:16], VEC[i][15:8]);
    wait_done(400, "R4 table batch completes");
    for (int i = 0; i < 6; i++) begin
      chk(m_word[base + i] == VEC[i][15:8], "R1 so word msb first", 32'(m_word[base + i]), 32'(VEC[i][15:8]));
      chk(m_cs[base + i] == exp_csn(VEC[i][17:16]), "R2 cs_n per entry", 32'(m_cs[base + i]), 32'(exp_csn(VEC[i][17:16])));
    end
    for (int i = 0; i < 6; i++) read_rx(VEC[i][7:0], "R9 rx order");
    chk(!rx_avail, "R9 rx drained", 32'(rx_avail), 32'd0);

    // R4: exact completion timing and single-cycle pulse
    pulse_clr();
    set_count(4'd1);
    sl_rep[m_n] = 8'h11;
    put_entry(2'd2, 8'hC7);
    repeat (34) @(posedge clk);
    @(negedge clk);
    chk(!done_irq, "R4 irq not early", 32'(done_irq), 32'd0);
    @(negedge clk);
    chk(done_irq, "R4 irq at 17*HALF+1", 32'(done_irq), 32'd1);
    @(negedge clk);
    chk(!done_irq, "R4 irq one cycle", 32'(done_irq), 32'd0);
    chk(cs_n == 4'hF, "R3 cs released after batch", 32'(cs_n), 32'hF);

    // R7: wait state with an empty queue mid-batch
    pulse_clr();
    set_count(4'd2);
    base = m_n;
    sl_rep[base] = 8'h21; sl_rep[base + 1] = 8'h43;
    put_entry(2'd1, 8'h96);
    repeat (45) @(negedge clk);
    begin
      bit held = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sck || cs_n != 4'hD || done_irq) held = 1'b0;
      end
      chk(held, "R7 sck parked low, cs held", {28'd0, cs_n}, 32'hD);
    end
    chk(m_n - base == 1, "R7 one word before stall", 32'(m_n - base), 32'd1);
    put_entry(2'd3, 8'h3E);
    wait_done(200, "R7 batch resumes");
    chk(m_word[base + 1] == 8'h3E && m_cs[base + 1] == 4'h7, "R7 resumed word",
        {20'd0, m_cs[base + 1], m_word[base + 1]}, 32'h73E);

    // R3: entries beyond the batch stay unsent; R5: clear discards them
    pulse_clr();
    set_count(4'd2);
    base = m_n;
    put_entry(2'd0, 8'h01); put_entry(2'd1, 8'h02); put_entry(2'd2, 8'h03);
    wait_done(200, "R3 short batch completes");
    repeat (80) @(negedge clk);
    chk(m_n - base == 2, "R3 only programmed count sent", 32'(m_n - base), 32'd2);
    chk(!sck && cs_n == 4'hF, "R3 engine stopped", {27'd0, sck, cs_n}, 32'hF);
    pulse_clr();
    chk(!rx_avail && !full, "R5 queues cleared", {30'd0, rx_avail, full}, 32'd0);
    set_count(4'd1);
    base = m_n;
    sl_rep[base] = 8'h5C;
    put_entry(2'd3, 8'hE4);
    wait_done(200, "R5 new batch completes");
    chk(m_word[base] == 8'hE4, "R5 stale entry discarded", 32'(m_word[base]), 32'hE4);
    read_rx(8'h5C, "R5 rx restarts at zero");

    // R6 R10 R3: fill while frozen, then a 16-word batch from count 0
    pulse_clr();
    en = 1'b0;
    set_count(4'd0);
    base = m_n;
    for (int i = 0; i < 16; i++) sl_rep[base + i] = 8'(i * 29 + 5);
    for (int i = 0; i < 15; i++) put_entry(2'(i % 4), 8'(i * 17 + 1));
    chk(!full, "R6 not full at 15", 32'(full), 32'd0);
    put_entry(2'(15 % 4), 8'(15 * 17 + 1));
    chk(full, "R6 full at 16", 32'(full), 32'd1);
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sck || cs_n != 4'hF) quiet = 1'b0;
      end
      chk(quiet && m_n == base, "R10 frozen while en low", 32'(m_n - base), 32'd0);
    end
    en = 1'b1;
    wait_done(1000, "R3 sixteen-word batch completes");
    chk(m_n - base == 16, "R3 count 0 means 16", 32'(m_n - base), 32'd16);
    for (int i = 0; i < 16; i++) begin
      chk(m_word[base + i] == 8'(i * 17 + 1) && m_cs[base + i] == exp_csn(2'(i % 4)), "R2 deep queue entry",
          {20'd0, m_cs[base + i], m_word[base + i]}, {20'd0, exp_csn(2'(i % 4)), 8'(i * 17 + 1)});
    end
    for (int i = 0; i < 16; i++) read_rx(8'(i * 29 + 5), "R9 deep rx order");

    // R8: receive-only keeps so at its last level
    pulse_clr();
    set_count(4'd2);
    lvl = so;
    rx_only = 1'b1;
    base = m_n;
    sl_rep[base] = 8'hB2; sl_rep[base + 1] = 8'h4D;
    put_entry(2'd0, 8'h55); put_entry(2'd1, 8'hAA);
    wait_done(200, "R8 dummy batch completes");
    chk(m_word[base] == {8{lvl}} && m_word[base + 1] == {8{lvl}}, "R8 so held",
        {16'd0, m_word[base], m_word[base + 1]}, {16'd0, {16{lvl}}});
    read_rx(8'hB2, "R8 rx still captured");
    read_rx(8'h4D, "R8 rx still captured");
    rx_only = 1'b0;

    // R9: receive disabled stores nothing
    pulse_clr();
    set_count(4'd1);
    rx_en = 1'b0;
    sl_rep[m_n] = 8'hEE;
    put_entry(2'd2, 8'h18);
    wait_done(200, "R9 batch without receive");
    @(negedge clk);
    chk(!rx_avail, "R9 rx_en low stores nothing", 32'(rx_avail), 32'd0);
    rx_en = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule